// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 64-bit status and control word of a scalar floating-point unit. The word carries the rounding controls (binary and decimal), the non-IEEE mode bit, five trap-enable bits, sticky exception flags with their two derived summaries, the rounding-outcome bits and a five-bit result-flags field. Software reads the whole word on `rd_data` and may overwrite it in one cycle.

The FPU side has its own update strobe. An update ORs new exception causes into the sticky flags. It can also load the result-flags field in either of two ways: from a built-in classifier that encodes a 64-bit IEEE double, or from a four-bit comparison outcome.

After any change, the invalid-operation summary and the enabled-exception summary are recomputed from the final value. The overall exception-summary bit is never derived and only moves when software writes it. Bit positions below are LSB-first, with bit 63 the most significant.

Top module: `fp_status_reg`

## Requirements
- R1: Bits 63:35 and bit 11 are reserved. They always read 0, whatever is written.
- R2: After reset, `rd_data` is all zeros.
- R3: When `sw_we` is high, every non-reserved bit other than 30 and 29 takes the value of `sw_wdata` on the next cycle. This covers rounding control 1:0, non-IEEE 2, enables 7:3, the result field 16:12, the rounding-outcome bits 18:17 and 34:32.
- R4: Bit 29 (invalid summary) always equals the OR of the nine invalid causes at bits 24:19 and 10:8. Any value written to bit 29 is ignored.
- R5: Bit 30 (enabled summary) always equals `(b29&b7)|(b28&b6)|(b27&b5)|(b26&b4)|(b25&b3)`. Any value written to bit 30 is ignored.
- R6: Bit 31 (exception summary) changes only through a software write. FPU updates leave it unchanged.
- R7: An FPU update (`fpu_upd`) ORs `fpu_exc` into the sticky flags and never clears one. The mapping is: index 0 to bit 25 (inexact), 1 to 26 (divide by zero), 2 to 27 (underflow), 3 to 28 (overflow), 4..9 to bits 24..19, 10 to 10, 11 to 9, 12 to 8.
- R8: An update with `fpu_cls_en` loads bits 16:12 with the class of `fpu_result`. The codes are: NaN 10001, −inf 01001, −normal 01000, −denormal 11000, −zero 10010, +zero 00010, +denormal 10100, +normal 00100, +inf 00101.
- R9: An update with `fpu_cmp_en` loads bits 15:12 from `fpu_cmp` (bit 3 less, 2 greater, 1 equal, 0 unordered) and leaves bit 16 as it was. If the classifier also loads in the same update, the comparison wins for bits 15:12.
- R10: When `sw_we` and `fpu_upd` are high in the same cycle, the software value is taken and the FPU update is discarded. The summaries are still recomputed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write value |
| fpu_upd | input | 1 | FPU update strobe |
| fpu_exc | input | 13 | Exception causes to OR into the sticky flags |
| fpu_cls_en | input | 1 | Load the result field from the classifier |
| fpu_result | input | 64 | Double-precision result to classify |
| fpu_cmp_en | input | 1 | Load the condition bits from `fpu_cmp` |
| fpu_cmp | input | 4 | Comparison outcome |
| rd_data | output | 64 | Current register value |

## Verification
Every result appears on `rd_data` one cycle after the stimulus: inputs sampled at a rising edge are visible right after that same edge. The driver applies each stimulus at a falling edge and queues the expected word at the same moment. The monitor pops one item per rising edge and compares it a fraction of a cycle later. Each queued item therefore meets exactly the edge that consumed its stimulus.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int REG_W   = 64;
   localparam int EXC_N   = 13;
   localparam int TOP_USED = 35;
   localparam int B_HOLE  = 11;

   localparam int B_ANY   = 31;
   localparam int B_ENSUM = 30;
   localparam int B_INV   = 29;
   localparam int B_OVF   = 28;
   localparam int B_UNF   = 27;
   localparam int B_DIVZ  = 26;
   localparam int B_INEX  = 25;
   localparam int B_ENOV  = 6;
   localparam int B_ENUN  = 5;
   localparam int B_ENDZ  = 4;
   localparam int B_ENIX  = 3;
   localparam int B_ENIV  = 7;
   localparam int RF_HI   = 16;
   localparam int RF_LO   = 12;

   localparam logic [4:0] CLS_NAN   = 5'b10001;
   localparam logic [4:0] CLS_NINF  = 5'b01001;
   localparam logic [4:0] CLS_NNORM = 5'b01000;
   localparam logic [4:0] CLS_NDEN  = 5'b11000;
   localparam logic [4:0] CLS_NZERO = 5'b10010;
   localparam logic [4:0] CLS_PZERO = 5'b00010;
   localparam logic [4:0] CLS_PDEN  = 5'b10100;
   localparam logic [4:0] CLS_PNORM = 5'b00100;
   localparam logic [4:0] CLS_PINF  = 5'b00101;

   function automatic bit bit_used(int i);
      return (i < TOP_USED) && (i != B_HOLE);
   endfunction

   function automatic logic [REG_W-1:0] exc_to_mask(logic [EXC_N-1:0] e);
      logic [REG_W-1:0] m;
      m = '0;
      m[B_INEX] = e[0];
      m[B_DIVZ] = e[1];
      m[B_UNF]  = e[2];
      m[B_OVF]  = e[3];
      m[24:19]  = e[9:4];
      m[10]     = e[10];
      m[9]      = e[11];
      m[8]      = e[12];
      return m;
   endfunction
endpackage

// File: rtl/fsr_classify.sv
module fsr_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int DW    = EXP_W + FRAC_W + 1
) (
   input  logic [DW-1:0] val,
   output logic [4:0]    code
);
   logic              sgn;
   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;

   assign sgn  = val[DW-1];
   assign expo = val[DW-2:FRAC_W];
   assign frac = val[FRAC_W-1:0];

   always_comb begin
      if (&expo) begin
         if (|frac) code = fsr_pkg::CLS_NAN;
         else       code = sgn ? fsr_pkg::CLS_NINF : fsr_pkg::CLS_PINF;
      end else if (expo == '0) begin
         if (|frac) code = sgn ? fsr_pkg::CLS_NDEN  : fsr_pkg::CLS_PDEN;
         else       code = sgn ? fsr_pkg::CLS_NZERO : fsr_pkg::CLS_PZERO;
      end else begin
         code = sgn ? fsr_pkg::CLS_NNORM : fsr_pkg::CLS_PNORM;
      end
   end
endmodule

// File: rtl/fsr_summary.sv
module fsr_summary (
   input  logic [fsr_pkg::REG_W-1:0] raw,
   output logic [fsr_pkg::REG_W-1:0] fixed
);
   localparam int W = fsr_pkg::REG_W;
   logic [W-1:0] keep;

   for (genvar i = 0; i < W; i++) begin : g_keep
      localparam bit USED = fsr_pkg::bit_used(i);
      assign keep[i] = USED;
   end

   always_comb begin
      logic [W-1:0] v;
      v = raw & keep;
      v[fsr_pkg::B_INV] = |{v[24:19], v[10:8]};
      v[fsr_pkg::B_ENSUM] =
         (v[fsr_pkg::B_INV]  & v[fsr_pkg::B_ENIV]) |
         (v[fsr_pkg::B_OVF]  & v[fsr_pkg::B_ENOV]) |
         (v[fsr_pkg::B_UNF]  & v[fsr_pkg::B_ENUN]) |
         (v[fsr_pkg::B_DIVZ] & v[fsr_pkg::B_ENDZ]) |
         (v[fsr_pkg::B_INEX] & v[fsr_pkg::B_ENIX]);
      fixed = v;
   end
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int DATA_W = EXP_W + FRAC_W + 1,
   localparam int W      = fsr_pkg::REG_W,
   localparam int EN     = fsr_pkg::EXC_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [W-1:0]      sw_wdata,
   input  logic              fpu_upd,
   input  logic [EN-1:0]     fpu_exc,
   input  logic              fpu_cls_en,
   input  logic [DATA_W-1:0] fpu_result,
   input  logic              fpu_cmp_en,
   input  logic [3:0]        fpu_cmp,
   output logic [W-1:0]      rd_data
);
   if (DATA_W != 64) begin : g_bad_width
      $error("fp_status_reg: classifier operand must be 64 bits wide");
   end
   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
      $error("fp_status_reg: exponent or fraction too narrow");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] merged;
   logic [W-1:0] next_val;
   logic [4:0]   cls_code;

   fsr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val  (fpu_result),
      .code (cls_code)
   );

   always_comb begin
      merged = state_q;
      if (fpu_upd) begin
         merged = merged | fsr_pkg::exc_to_mask(fpu_exc);
         if (fpu_cls_en) merged[fsr_pkg::RF_HI:fsr_pkg::RF_LO] = cls_code;
         if (fpu_cmp_en) merged[fsr_pkg::RF_HI-1:fsr_pkg::RF_LO] = fpu_cmp;
      end
      if (sw_we) merged = sw_wdata;
   end

   fsr_summary u_sum (
      .raw   (merged),
      .fixed (next_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= next_val;
   end

   assign rd_data = state_q;
endmodule

// File: rtl/fp_status_reg_chk.sv
module fp_status_reg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sw_we,
   input logic [63:0] rd_data
);
   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[63:35] == '0) && !rd_data[11]);

   // R4
   inv_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[29] == |{rd_data[24:19], rd_data[10:8]});

   // R5
   en_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[30] == ((rd_data[29] & rd_data[7]) | (rd_data[28] & rd_data[6]) |
                      (rd_data[27] & rd_data[5]) | (rd_data[26] & rd_data[4]) |
                      (rd_data[25] & rd_data[3])));

   // R6
   any_exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_we |=> $stable(rd_data[31]));

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_we |=> ((rd_data[28:19] & $past(rd_data[28:19])) == $past(rd_data[28:19])));
endmodule

bind fp_status_reg fp_status_reg_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sw_we   (sw_we),
   .rd_data (rd_data)
);

// File: tb/fp_status_reg_bench.sv
`timescale 1ns/100ps
module fp_status_reg_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        sw_we = 0;
   logic [63:0] sw_wdata = '0;
   logic        fpu_upd = 0;
   logic [12:0] fpu_exc = '0;
   logic        fpu_cls_en = 0;
   logic [63:0] fpu_result = '0;
   logic        fpu_cmp_en = 0;
   logic [3:0]  fpu_cmp = '0;
   logic [63:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [63:0] model = '0;
   logic [63:0] exp_q[$];
   string       req_q[$];

   always #2.5 clk = ~clk;

   fp_status_reg u_fp_status_reg (
      .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
      .fpu_upd(fpu_upd), .fpu_exc(fpu_exc), .fpu_cls_en(fpu_cls_en),
      .fpu_result(fpu_result), .fpu_cmp_en(fpu_cmp_en), .fpu_cmp(fpu_cmp),
      .rd_data(rd_data)
   );

   function automatic logic [4:0] ref_class(logic [63:0] d);
      logic s = d[63];
      if (d[62:52] == 11'h7FF) return (d[51:0] != 0) ? 5'b10001 : (s ? 5'b01001 : 5'b00101);
      if (d[62:52] == 11'h000) begin
         if (d[51:0] != 0) return s ? 5'b11000 : 5'b10100;
         return s ? 5'b10010 : 5'b00010;
      end
      return s ? 5'b01000 : 5'b00100;
   endfunction

   function automatic logic [63:0] settle(logic [63:0] v);
      v[63:35] = '0;
      v[11] = 1'b0;
      v[29] = |{v[24:19], v[10:8]};
      v[30] = (v[29] & v[7]) | (v[28] & v[6]) | (v[27] & v[5]) | (v[26] & v[4]) | (v[25] & v[3]);
      return v;
   endfunction

   task automatic drive(input bit we, input logic [63:0] wd, input bit upd,
                        input logic [12:0] exc, input bit cls, input logic [63:0] res,
                        input bit cmpe, input logic [3:0] cmp, input string req);
      logic [63:0] n;
      @(negedge clk);
      sw_we = we; sw_wdata = wd; fpu_upd = upd; fpu_exc = exc;
      fpu_cls_en = cls; fpu_result = res; fpu_cmp_en = cmpe; fpu_cmp = cmp;
      n = model;
      if (upd) begin
         n[25] |= exc[0]; n[26] |= exc[1]; n[27] |= exc[2]; n[28] |= exc[3];
         n[24:19] |= exc[9:4]; n[10] |= exc[10]; n[9] |= exc[11]; n[8] |= exc[12];
         if (cls)  n[16:12] = ref_class(res);
         if (cmpe) n[15:12] = cmp;
      end
      if (we) n = wd;
      model = settle(n);
      exp_q.push_back(model);
      req_q.push_back(req);
   endtask

   task automatic sw(input logic [63:0] wd, input string req);
      drive(1, wd, 0, '0, 0, '0, 0, '0, req);
   endtask

   task automatic fpu(input logic [12:0] exc, input bit cls, input logic [63:0] res,
                      input bit cmpe, input logic [3:0] cmp, input string req);
      drive(0, '0, 1, exc, cls, res, cmpe, cmp, req);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [63:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s: got %h expected %h", r, rd_data, e);
            end
         end
      end
   end

   initial begin : watchdog
      #100000;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      checks++;
      if (rd_data !== '0) begin
         errors++;
         $display("FAIL R2: got %h expected %h", rd_data, 64'h0);
      end
      rst_n = 1;
      @(negedge clk);
      checks++;
      if (rd_data !== '0) begin
         errors++;
         $display("FAIL R2: got %h expected %h", rd_data, 64'h0);
      end
      // R1 R3: all ones, reserved masked, summaries derived
      sw('1, "R1_R3");
      // R4 R5: written summary bits without causes are dropped
      sw(64'h0000_0000_6000_00FF, "R4_R5");
      // R4: lone square-root cause, invalid trap disabled
      sw(64'h0000_0000_0000_0200, "R4");
      // R5: enable the invalid trap
      sw(64'h0000_0000_0000_0280, "R5");
      // R3: rounding fields and outcome bits load
      sw(64'h0000_0007_0006_1003, "R3");
      sw(64'h0, "R3");
      // R7 R6: overflow and zero/zero with matching enables via software first
      sw(64'h0000_0000_0000_0040, "R5");
      fpu(13'b0_0000_1000_1000, 0, '0, 0, '0, "R7_R6");
      fpu(13'b0, 0, '0, 0, '0, "R7");
      fpu(13'b1_0000_0000_0001, 0, '0, 0, '0, "R7");
      // R6: software sets the summary, FPU leaves it
      sw(64'h0000_0000_8000_0000, "R6");
      fpu(13'b0_0000_0000_0100, 0, '0, 0, '0, "R6");
      // R8: classifier cases
      fpu('0, 1, 64'h0000_0000_0000_0000, 0, '0, "R8 +zero");
      fpu('0, 1, 64'h8000_0000_0000_0000, 0, '0, "R8 -zero");
      fpu('0, 1, 64'h0000_0000_0000_0001, 0, '0, "R8 +den");
      fpu('0, 1, 64'h8000_0000_0000_0001, 0, '0, "R8 -den");
      fpu('0, 1, 64'h3FF0_0000_0000_0000, 0, '0, "R8 +norm");
      fpu('0, 1, 64'hBFF0_0000_0000_0000, 0, '0, "R8 -norm");
      fpu('0, 1, 64'h7FF0_0000_0000_0000, 0, '0, "R8 +inf");
      fpu('0, 1, 64'hFFF0_0000_0000_0000, 0, '0, "R8 -inf");
      fpu('0, 1, 64'h7FF8_0000_0000_0000, 0, '0, "R8 nan");
      fpu('0, 1, 64'hFFF0_0000_0000_0001, 0, '0, "R8 nan2");
      // R9: compare loads condition bits, class bit kept
      fpu('0, 0, '0, 1, 4'b0010, "R9");
      fpu('0, 1, 64'h8000_0000_0000_0001, 1, 4'b0100, "R9 both");
      // R10: software wins over a simultaneous update
      drive(1, 64'h0000_0000_0000_0010, 1, '1, 1, 64'h7FF0_0000_0000_0000, 1, 4'b1111, "R10");
      drive(1, 64'h0000_0000_0000_0008, 1, 13'b0_0000_0000_0001, 0, '0, 0, '0, "R10");
      drive(0, '0, 0, '0, 0, '0, 0, '0, "idle");
      wait (exp_q.size() == 0);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule